// File: doc/BRIEF.md
# First Parity Error Capture Register

This block watches the parity check results of two kinds of data path and keeps a record of the first parity failure seen after it is armed. One kind is the drum path, where a check covers one of the bytes that travel to or from the drum. The other is buffer read-out, where a check covers a word read from one of the buffers. Once a record is held, later failures do not change it.

When the host asks for parity status, the block answers one cycle later with a 30-bit status word built from the record. The word carries a data-available flag, a one-hot byte designator for a drum failure, or a one-hot buffer designator for a buffer failure, the read/write mode of the instruction that was running, and the track and word addresses captured at the failure. For a buffer failure the address fields have no meaning, so the block forces them to zero. A completed status read or a master clear empties the record and re-arms the capture for the next first failure.

Top module: `fpe_capture`

## Requirements
- R1: After reset `stat_vld` is 0 and `stat_word` is 0. While no record is held, a status read returns an all-zero word.
- R2: A drum failure on byte index i captures a record. The word then reads as follows: bit 29 is 1, bit 27+i is 1, bits 26:25 are 0, bit 24 is the mode (1 = write, 0 = read), bits 18:10 hold `trk_addr` and bits 9:0 hold `word_addr` as they were sampled in the failure cycle.
- R3: A buffer failure on buffer index j captures a record. The word then reads as follows: bit 29 is 1, bit 25+j is 1, bits 28:27 are 0, bit 24 is the mode, and bits 18:0 are all 0 whatever the address inputs were.
- R4: While a record is held, further drum or buffer failures leave it unchanged.
- R5: If a drum failure and a buffer failure arrive in the same cycle with no record held, the drum failure is recorded.
- R6: Bits 23:19 of the status word are always 0.
- R7: A `stat_req` pulse in cycle N gives `stat_vld` high for exactly one cycle, N+1. The word returned shows the record as it stood before the edge that ends cycle N.
- R8: A completed status read empties the record, so the next read returns 0 unless a new failure arrives in between.
- R9: A failure that arrives in the same cycle as `stat_req` is not lost. The response shows the old record, and the failure becomes the new record.
- R10: `mclr` empties the record. A failure in the same cycle as `mclr` is dropped.
- R11: At most one designator bit among bits 28:25 is ever 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclr | input | 1 | Master clear, empties the record |
| drum_err | input | 1 | Drum-path parity failure this cycle |
| drum_byte | input | 1 | Index of the failing drum byte |
| buf_err | input | 1 | Buffer read-out parity failure this cycle |
| buf_idx | input | 1 | Index of the failing buffer |
| wr_mode | input | 1 | Running instruction is a write (1) or a read (0) |
| trk_addr | input | 9 | Track address in use |
| word_addr | input | 10 | Word address in use |
| stat_req | input | 1 | Parity status request pulse |
| stat_vld | output | 1 | Status word valid, one cycle |
| stat_word | output | 30 | Formatted status word |

## Verification
Two functions can fall in the same cycle: the capture of a new failure, and the read-and-clear that a status request triggers. Master clear can also meet a failure in the same cycle. The bench first builds a buffer record. It then raises `stat_req` together with a drum failure. It expects the immediate response to carry the buffer record and a second read to carry the drum record. A failure raised together with `mclr` must leave the next read at zero.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

   // Source of the candidate record for this cycle
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_DRUM = 2'd1,
      SRC_BUF  = 2'd2
   } fpe_src_e;

   // Default geometry of the status word
   localparam int unsigned DEF_WORD_W    = 10;
   localparam int unsigned DEF_TRACK_W   = 9;
   localparam int unsigned DEF_SPARE_W   = 5;
   localparam int unsigned DEF_NUM_BYTES = 2;
   localparam int unsigned DEF_NUM_BUFS  = 2;

   // Index width helper that never returns zero
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/fpe_arbiter.sv
module fpe_arbiter
   import fpe_pkg::*;
#(
   parameter int unsigned NUM_BYTES     = DEF_NUM_BYTES,
   parameter int unsigned NUM_BUFS      = DEF_NUM_BUFS,
   parameter int unsigned TRACK_W       = DEF_TRACK_W,
   parameter int unsigned WORD_W        = DEF_WORD_W,
   parameter bit          ZERO_BUF_ADDR = 1'b1,
   localparam int unsigned BYTE_IW      = idx_w(NUM_BYTES),
   localparam int unsigned BUF_IW       = idx_w(NUM_BUFS)
) (
   input  logic                 drum_err,
   input  logic [BYTE_IW-1:0]   drum_byte,
   input  logic                 buf_err,
   input  logic [BUF_IW-1:0]    buf_idx,
   input  logic                 wr_mode,
   input  logic [TRACK_W-1:0]   trk_addr,
   input  logic [WORD_W-1:0]    word_addr,
   output logic                 cand_vld,
   output fpe_src_e             cand_src,
   output logic [NUM_BYTES-1:0] cand_byte_oh,
   output logic [NUM_BUFS-1:0]  cand_buf_oh,
   output logic                 cand_mode,
   output logic [TRACK_W-1:0]   cand_trk,
   output logic [WORD_W-1:0]    cand_wa
);

   logic [NUM_BYTES-1:0] byte_dec;
   logic [NUM_BUFS-1:0]  buf_dec;
   logic                 take_drum;
   logic                 take_buf;

   // One-hot decode of the drum byte index
   for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_byte_dec
      assign byte_dec[gi] = (drum_byte == BYTE_IW'(gi));
   end

   // One-hot decode of the buffer index
   for (genvar gj = 0; gj < NUM_BUFS; gj++) begin : g_buf_dec
      assign buf_dec[gj] = (buf_idx == BUF_IW'(gj));
   end

   // Drum path has priority over buffer read-out
   assign take_drum = drum_err;
   assign take_buf  = buf_err & ~drum_err;
   assign cand_vld  = take_drum | take_buf;

   always_comb begin
      if (take_drum)     cand_src = SRC_DRUM;
      else if (take_buf) cand_src = SRC_BUF;
      else               cand_src = SRC_NONE;
   end

   assign cand_byte_oh = take_drum ? byte_dec : '0;
   assign cand_buf_oh  = take_buf  ? buf_dec  : '0;
   assign cand_mode    = cand_vld & wr_mode;

   // Address fields: a buffer failure either zeroes them or passes them on
   if (ZERO_BUF_ADDR) begin : g_zero_addr
      assign cand_trk = take_drum ? trk_addr  : '0;
      assign cand_wa  = take_drum ? word_addr : '0;
   end else begin : g_pass_addr
      assign cand_trk = cand_vld ? trk_addr  : '0;
      assign cand_wa  = cand_vld ? word_addr : '0;
   end

endmodule

// File: rtl/fpe_record.sv
module fpe_record
   import fpe_pkg::*;
#(
   parameter int unsigned NUM_BYTES = DEF_NUM_BYTES,
   parameter int unsigned NUM_BUFS  = DEF_NUM_BUFS,
   parameter int unsigned TRACK_W   = DEF_TRACK_W,
   parameter int unsigned WORD_W    = DEF_WORD_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mclr,
   input  logic                 stat_req,
   input  logic                 cand_vld,
   input  fpe_src_e             cand_src,
   input  logic [NUM_BYTES-1:0] cand_byte_oh,
   input  logic [NUM_BUFS-1:0]  cand_buf_oh,
   input  logic                 cand_mode,
   input  logic [TRACK_W-1:0]   cand_trk,
   input  logic [WORD_W-1:0]    cand_wa,
   output logic                 rec_vld,
   output fpe_src_e             rec_src,
   output logic [NUM_BYTES-1:0] rec_byte_oh,
   output logic [NUM_BUFS-1:0]  rec_buf_oh,
   output logic                 rec_mode,
   output logic [TRACK_W-1:0]   rec_trk,
   output logic [WORD_W-1:0]    rec_wa
);

   logic armed;
   logic do_load;
   logic do_clear;

   // Armed when empty, or when a read empties it at this edge
   assign armed    = ~rec_vld | stat_req;
   assign do_load  = ~mclr & cand_vld & armed;
   assign do_clear = mclr | (stat_req & ~do_load);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_vld     <= 1'b0;
         rec_src     <= SRC_NONE;
         rec_byte_oh <= '0;
         rec_buf_oh  <= '0;
         rec_mode    <= 1'b0;
         rec_trk     <= '0;
         rec_wa      <= '0;
      end else if (do_load) begin
         rec_vld     <= 1'b1;
         rec_src     <= cand_src;
         rec_byte_oh <= cand_byte_oh;
         rec_buf_oh  <= cand_buf_oh;
         rec_mode    <= cand_mode;
         rec_trk     <= cand_trk;
         rec_wa      <= cand_wa;
      end else if (do_clear) begin
         rec_vld     <= 1'b0;
         rec_src     <= SRC_NONE;
         rec_byte_oh <= '0;
         rec_buf_oh  <= '0;
         rec_mode    <= 1'b0;
         rec_trk     <= '0;
         rec_wa      <= '0;
      end
   end

endmodule

// File: rtl/fpe_formatter.sv
module fpe_formatter
   import fpe_pkg::*;
#(
   parameter int unsigned NUM_BYTES = DEF_NUM_BYTES,
   parameter int unsigned NUM_BUFS  = DEF_NUM_BUFS,
   parameter int unsigned TRACK_W   = DEF_TRACK_W,
   parameter int unsigned WORD_W    = DEF_WORD_W,
   parameter int unsigned SPARE_W   = DEF_SPARE_W,
   localparam int unsigned MODE_POS  = WORD_W + TRACK_W + SPARE_W,
   localparam int unsigned BUF_LSB   = MODE_POS + 1,
   localparam int unsigned BYTE_LSB  = BUF_LSB + NUM_BUFS,
   localparam int unsigned AVAIL_POS = BYTE_LSB + NUM_BYTES,
   localparam int unsigned STAT_W    = AVAIL_POS + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 stat_req,
   input  logic                 rec_vld,
   input  logic [NUM_BYTES-1:0] rec_byte_oh,
   input  logic [NUM_BUFS-1:0]  rec_buf_oh,
   input  logic                 rec_mode,
   input  logic [TRACK_W-1:0]   rec_trk,
   input  logic [WORD_W-1:0]    rec_wa,
   output logic [STAT_W-1:0]    rec_word,
   output logic                 stat_vld,
   output logic [STAT_W-1:0]    stat_word
);

   // Pack the record; an empty record reads as all zero
   always_comb begin
      rec_word = '0;
      if (rec_vld) begin
         rec_word[AVAIL_POS]                    = 1'b1;
         rec_word[BYTE_LSB +: NUM_BYTES]        = rec_byte_oh;
         rec_word[BUF_LSB +: NUM_BUFS]          = rec_buf_oh;
         rec_word[MODE_POS]                     = rec_mode;
         rec_word[WORD_W +: TRACK_W]            = rec_trk;
         rec_word[0 +: WORD_W]                  = rec_wa;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_vld  <= 1'b0;
         stat_word <= '0;
      end else begin
         stat_vld <= stat_req;
         if (stat_req) stat_word <= rec_word;
      end
   end

endmodule

// File: rtl/fpe_capture.sv
module fpe_capture
   import fpe_pkg::*;
#(
   parameter int unsigned NUM_BYTES     = DEF_NUM_BYTES,
   parameter int unsigned NUM_BUFS      = DEF_NUM_BUFS,
   parameter int unsigned TRACK_W       = DEF_TRACK_W,
   parameter int unsigned WORD_W        = DEF_WORD_W,
   parameter int unsigned SPARE_W       = DEF_SPARE_W,
   parameter bit          ZERO_BUF_ADDR = 1'b1,
   localparam int unsigned BYTE_IW   = idx_w(NUM_BYTES),
   localparam int unsigned BUF_IW    = idx_w(NUM_BUFS),
   localparam int unsigned STAT_W    = WORD_W + TRACK_W + SPARE_W + 2 + NUM_BUFS + NUM_BYTES
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mclr,
   input  logic                drum_err,
   input  logic [BYTE_IW-1:0]  drum_byte,
   input  logic                buf_err,
   input  logic [BUF_IW-1:0]   buf_idx,
   input  logic                wr_mode,
   input  logic [TRACK_W-1:0]  trk_addr,
   input  logic [WORD_W-1:0]   word_addr,
   input  logic                stat_req,
   output logic                stat_vld,
   output logic [STAT_W-1:0]   stat_word
);

   // Elaboration-time parameter checks
   if (NUM_BYTES < 2) begin : g_bad_bytes
      $error("fpe_capture: NUM_BYTES must be at least 2");
   end
   if (NUM_BUFS < 2) begin : g_bad_bufs
      $error("fpe_capture: NUM_BUFS must be at least 2");
   end
   if (TRACK_W < 1 || WORD_W < 1) begin : g_bad_addr
      $error("fpe_capture: address fields need a width");
   end

   logic                 cand_vld;
   fpe_src_e             cand_src;
   logic [NUM_BYTES-1:0] cand_byte_oh;
   logic [NUM_BUFS-1:0]  cand_buf_oh;
   logic                 cand_mode;
   logic [TRACK_W-1:0]   cand_trk;
   logic [WORD_W-1:0]    cand_wa;

   logic                 rec_vld;
   fpe_src_e             rec_src;
   logic [NUM_BYTES-1:0] rec_byte_oh;
   logic [NUM_BUFS-1:0]  rec_buf_oh;
   logic                 rec_mode;
   logic [TRACK_W-1:0]   rec_trk;
   logic [WORD_W-1:0]    rec_wa;
   logic [STAT_W-1:0]    rec_word;

   fpe_arbiter #(
      .NUM_BYTES     (NUM_BYTES),
      .NUM_BUFS      (NUM_BUFS),
      .TRACK_W       (TRACK_W),
      .WORD_W        (WORD_W),
      .ZERO_BUF_ADDR (ZERO_BUF_ADDR)
   ) u_arb (
      .drum_err     (drum_err),
      .drum_byte    (drum_byte),
      .buf_err      (buf_err),
      .buf_idx      (buf_idx),
      .wr_mode      (wr_mode),
      .trk_addr     (trk_addr),
      .word_addr    (word_addr),
      .cand_vld     (cand_vld),
      .cand_src     (cand_src),
      .cand_byte_oh (cand_byte_oh),
      .cand_buf_oh  (cand_buf_oh),
      .cand_mode    (cand_mode),
      .cand_trk     (cand_trk),
      .cand_wa      (cand_wa)
   );

   fpe_record #(
      .NUM_BYTES (NUM_BYTES),
      .NUM_BUFS  (NUM_BUFS),
      .TRACK_W   (TRACK_W),
      .WORD_W    (WORD_W)
   ) u_rec (
      .clk          (clk),
      .rst_n        (rst_n),
      .mclr         (mclr),
      .stat_req     (stat_req),
      .cand_vld     (cand_vld),
      .cand_src     (cand_src),
      .cand_byte_oh (cand_byte_oh),
      .cand_buf_oh  (cand_buf_oh),
      .cand_mode    (cand_mode),
      .cand_trk     (cand_trk),
      .cand_wa      (cand_wa),
      .rec_vld      (rec_vld),
      .rec_src      (rec_src),
      .rec_byte_oh  (rec_byte_oh),
      .rec_buf_oh   (rec_buf_oh),
      .rec_mode     (rec_mode),
      .rec_trk      (rec_trk),
      .rec_wa       (rec_wa)
   );

   fpe_formatter #(
      .NUM_BYTES (NUM_BYTES),
      .NUM_BUFS  (NUM_BUFS),
      .TRACK_W   (TRACK_W),
      .WORD_W    (WORD_W),
      .SPARE_W   (SPARE_W)
   ) u_fmt (
      .clk         (clk),
      .rst_n       (rst_n),
      .stat_req    (stat_req),
      .rec_vld     (rec_vld),
      .rec_byte_oh (rec_byte_oh),
      .rec_buf_oh  (rec_buf_oh),
      .rec_mode    (rec_mode),
      .rec_trk     (rec_trk),
      .rec_wa      (rec_wa),
      .rec_word    (rec_word),
      .stat_vld    (stat_vld),
      .stat_word   (stat_word)
   );

endmodule

// File: rtl/fpe_capture_chk.sv
module fpe_capture_chk #(
   parameter int unsigned NUM_BYTES = 2,
   parameter int unsigned NUM_BUFS  = 2,
   parameter int unsigned TRACK_W   = 9,
   parameter int unsigned WORD_W    = 10,
   parameter int unsigned SPARE_W   = 5,
   localparam int unsigned ADDR_W    = WORD_W + TRACK_W,
   localparam int unsigned MODE_POS  = ADDR_W + SPARE_W,
   localparam int unsigned BUF_LSB   = MODE_POS + 1,
   localparam int unsigned BYTE_LSB  = BUF_LSB + NUM_BUFS,
   localparam int unsigned AVAIL_POS = BYTE_LSB + NUM_BYTES,
   localparam int unsigned STAT_W    = AVAIL_POS + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mclr,
   input logic              stat_req,
   input logic              stat_vld,
   input logic [STAT_W-1:0] stat_word,
   input logic              rec_vld,
   input logic [STAT_W-1:0] rec_word
);

   // R7: a request is answered in the next cycle
   a_r7_vld_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      stat_req |=> stat_vld);

   // R7: no response without a request
   a_r7_vld_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      stat_vld |-> $past(stat_req));

   // R6: spare bits read as zero
   a_r6_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
      stat_vld |-> (stat_word[MODE_POS-1:ADDR_W] == '0));

   // R11: never more than one designator bit
   a_r11_one_designator: assert property (@(posedge clk) disable iff (!rst_n)
      stat_vld |-> $onehot0(stat_word[AVAIL_POS-1:BUF_LSB]));

   // R3: buffer failures report zero addresses
   a_r3_buf_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_vld && (stat_word[BYTE_LSB-1:BUF_LSB] != '0)) |-> (stat_word[ADDR_W-1:0] == '0));

   // R1: an empty record reads as all zero
   a_r1_empty_word: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_vld && !stat_word[AVAIL_POS]) |-> (stat_word == '0));

   // R10: master clear empties the record
   a_r10_mclr_clears: assert property (@(posedge clk) disable iff (!rst_n)
      mclr |=> !rec_vld);

   // R4: a held record is stable until read or cleared
   a_r4_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_vld && !stat_req && !mclr) |=> (rec_vld && $stable(rec_word)));

endmodule

bind fpe_capture fpe_capture_chk #(
   .NUM_BYTES (NUM_BYTES),
   .NUM_BUFS  (NUM_BUFS),
   .TRACK_W   (TRACK_W),
   .WORD_W    (WORD_W),
   .SPARE_W   (SPARE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mclr      (mclr),
   .stat_req  (stat_req),
   .stat_vld  (stat_vld),
   .stat_word (stat_word),
   .rec_vld   (rec_vld),
   .rec_word  (rec_word)
);

// File: tb/fpe_capture_test.sv
`timescale 1ns/1ps
module fpe_capture_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mclr = 1'b0;
   logic        drum_err = 1'b0;
   logic [0:0]  drum_byte = '0;
   logic        buf_err = 1'b0;
   logic [0:0]  buf_idx = '0;
   logic        wr_mode = 1'b0;
   logic [8:0]  trk_addr = '0;
   logic [9:0]  word_addr = '0;
   logic        stat_req = 1'b0;
   logic        stat_vld;
   logic [29:0] stat_word;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   logic [29:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   fpe_capture uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mclr      (mclr),
      .drum_err  (drum_err),
      .drum_byte (drum_byte),
      .buf_err   (buf_err),
      .buf_idx   (buf_idx),
      .wr_mode   (wr_mode),
      .trk_addr  (trk_addr),
      .word_addr (word_addr),
      .stat_req  (stat_req),
      .stat_vld  (stat_vld),
      .stat_word (stat_word)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [29:0] mk_word(input logic avail, input logic [1:0] byte_oh,
                                           input logic [1:0] buf_oh, input logic mode,
                                           input logic [8:0] trk, input logic [9:0] wa);
      return {avail, byte_oh, buf_oh, mode, 5'b00000, trk, wa};
   endfunction

   // Monitor: pop and compare every response
   always @(negedge clk) begin
      if (rst_n && stat_vld) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected response", {2'b0, stat_word}, 32'h0);
         end else begin
            logic [29:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(stat_word === e, t, {2'b0, stat_word}, {2'b0, e});
            check($countones(stat_word[28:25]) <= 1, "R11 designators",
                  {2'b0, stat_word}, {2'b0, e});
         end
      end
   end

   // Driver: issue a status request and queue its expected word
   task automatic request(input logic [29:0] exp, input string tag);
      @(negedge clk);
      stat_req = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      stat_req = 1'b0;
      @(negedge clk);
      check(stat_vld == 1'b0, "R7 valid lasts one cycle", {31'b0, stat_vld}, 32'h0);
   endtask

   task automatic drum_fail(input logic idx, input logic wr, input logic [8:0] trk, input logic [9:0] wa);
      @(negedge clk);
      drum_err = 1'b1; drum_byte = idx; wr_mode = wr; trk_addr = trk; word_addr = wa;
      @(negedge clk);
      drum_err = 1'b0;
   endtask

   task automatic buf_fail(input logic idx, input logic wr, input logic [8:0] trk, input logic [9:0] wa);
      @(negedge clk);
      buf_err = 1'b1; buf_idx = idx; wr_mode = wr; trk_addr = trk; word_addr = wa;
      @(negedge clk);
      buf_err = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(stat_vld == 1'b0, "R1 reset valid", {31'b0, stat_vld}, 32'h0);
      check(stat_word == '0, "R1 reset word", {2'b0, stat_word}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: empty record reads zero
      request('0, "R1 empty read");

      // R2 / R4 / R6: first drum failure kept, later ones ignored
      drum_fail(1'b1, 1'b1, 9'h1A5, 10'h2F3);
      drum_fail(1'b0, 1'b0, 9'h011, 10'h022);
      buf_fail(1'b0, 1'b0, 9'h033, 10'h044);
      request(mk_word(1, 2'b10, 2'b00, 1, 9'h1A5, 10'h2F3), "R2 R4 R6 drum record");
      // R8: read emptied the record
      request('0, "R8 cleared after read");

      // R3: buffer failure zeroes addresses
      buf_fail(1'b0, 1'b0, 9'h1FF, 10'h3FF);
      request(mk_word(1, 2'b00, 2'b01, 0, 9'h0, 10'h0), "R3 buffer record");

      // R2 boundary: byte 0, read, all-ones addresses
      drum_fail(1'b0, 1'b0, 9'h1FF, 10'h3FF);
      request(mk_word(1, 2'b01, 2'b00, 0, 9'h1FF, 10'h3FF), "R2 max addresses");

      // R5: same-cycle drum and buffer failures
      @(negedge clk);
      drum_err = 1'b1; drum_byte = 1'b0; buf_err = 1'b1; buf_idx = 1'b1;
      wr_mode = 1'b0; trk_addr = 9'h0C3; word_addr = 10'h155;
      @(negedge clk);
      drum_err = 1'b0; buf_err = 1'b0;
      request(mk_word(1, 2'b01, 2'b00, 0, 9'h0C3, 10'h155), "R5 drum wins");

      // R9: failure in the request cycle
      buf_fail(1'b1, 1'b1, 9'h100, 10'h200);
      @(negedge clk);
      stat_req = 1'b1;
      drum_err = 1'b1; drum_byte = 1'b0; wr_mode = 1'b1; trk_addr = 9'h055; word_addr = 10'h1AA;
      exp_q.push_back(mk_word(1, 2'b00, 2'b10, 1, 9'h0, 10'h0));
      tag_q.push_back("R9 old record returned");
      @(negedge clk);
      stat_req = 1'b0; drum_err = 1'b0;
      @(negedge clk);
      request(mk_word(1, 2'b01, 2'b00, 1, 9'h055, 10'h1AA), "R9 new record kept");

      // R10: master clear empties the record
      drum_fail(1'b1, 1'b0, 9'h0AA, 10'h0BB);
      @(negedge clk); mclr = 1'b1;
      @(negedge clk); mclr = 1'b0;
      request('0, "R10 cleared by mclr");

      // R10: failure in the mclr cycle dropped
      @(negedge clk);
      mclr = 1'b1; buf_err = 1'b1; buf_idx = 1'b0;
      @(negedge clk);
      mclr = 1'b0; buf_err = 1'b0;
      request('0, "R10 failure dropped");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R7 all responses seen", exp_q.size(), 32'h0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   // Watchdog
   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

endmodule